// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This engine sits between a transmit word queue, a receive word queue and a byte-wide SPI shifter. After a start pulse it pulls 32-bit words from the transmit queue one at a time. Each word goes to the shifter as a series of bytes, lowest byte first. The bytes that come back from the shifter are packed into a receive word in the same byte positions, and that word is written to the receive queue. A signed counter tracks how many burst bits remain. It is reloaded from the programmed length field whenever it has run out, so one burst may span several words, and the last word of a burst may carry fewer than four bytes.

The engine also keeps the status events that surround a burst up to date. It pulses a transfer-complete event when a burst ends, unless multi-burst mode is active. It pulses an overflow event when a finished word has nowhere to go. It holds an exchange-request level while bursts chain back to back, and it drops that level when the transmit queue runs dry. Multi-burst mode is decided from three mode inputs: the selected channel is master, start-mode-control is clear, and the slave-select-control bit of the selected channel is set. Bit timing, clock generation and chip-select handling belong to the shifter and are not part of this engine.

Top module: `spi_burst_engine`

## Requirements
- R1: The burst length in bits is `burst_len_field + 1`. It is loaded into a signed running counter at a word fetch whenever the counter is zero or negative. The counter keeps its value between start pulses.
- R2: Each popped transmit word produces ceil(min(remaining bits, 32) / 8) byte exchanges. The counter drops by 8 after each exchange.
- R3: Transmit bytes leave a word lowest byte first: exchange i carries bits [8i+7:8i] of the word.
- R4: The response byte of exchange i is placed at bits [8i+7:8i] of the receive word. Byte positions with no exchange read as zero.
- R5: When a word is finished, the engine pulses `ovf_set` and drops the word if `rx_full` is high. Otherwise it pulses `rx_push` with the word. The two pulses never occur together.
- R6: Multi-burst mode is `mode_master & ~mode_smc & mode_ss_wave`. In this mode, `xch` is set at each word fetch and stays high while bursts continue.
- R7: When a finished word leaves the counter at zero or below, `tc_set` pulses only if multi-burst mode is inactive.
- R8: A word fetch that finds `tx_empty` high pulses `tc_set`, clears `xch` and returns the engine to idle.
- R9: `busy` rises on the cycle after an accepted start and stays high until the transmit queue is found empty. A start pulse while busy has no effect.
- R10: Once `byte_valid` is high, it and `byte_out` stay unchanged until `byte_ready` is seen.
- R11: `tx_pop` is a one-cycle pulse, one per word. It is raised only while `tx_empty` is low, and `tx_data` is taken on that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; honoured only while idle |
| burst_len_field | input | LEN_W | Burst length minus one, in bits |
| mode_master | input | 1 | Selected channel is master |
| mode_smc | input | 1 | Start-mode-control bit |
| mode_ss_wave | input | 1 | Slave-select-control bit of the selected channel |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_data | input | WORD_W | Head word of the transmit queue (first-word fall-through) |
| tx_pop | output | 1 | Pop the head transmit word |
| rx_full | input | 1 | Receive queue is full |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| rx_data | output | WORD_W | Assembled receive word |
| byte_valid | output | 1 | A byte is offered to the shifter |
| byte_ready | input | 1 | The shifter takes the offered byte |
| byte_out | output | 8 | Byte offered to the shifter |
| rsp_valid | input | 1 | The shifter returns the received byte |
| rsp_byte | input | 8 | Byte received by the shifter |
| busy | output | 1 | Engine is running |
| xch | output | 1 | Exchange-request level held during multi-burst chaining |
| tc_set | output | 1 | Transfer-complete event pulse |
| ovf_set | output | 1 | Receive overflow event pulse |

## Verification
The assertions assume that the transmit queue presents its head word and a correct empty flag before the pop, and that `rsp_valid` arrives only after the shifter has accepted a byte. The bench's queue model and shifter model keep to both. The assertions also assume that the mode inputs and the length field stay constant while the engine is busy. The bench changes them only between runs, after `busy` has fallen.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_WAIT,
    ST_STORE
  } eng_state_t;

  // Number of bits in a burst for a given length field.
  function automatic int unsigned burst_bits(input int unsigned len_field);
    return len_field + 1;
  endfunction

  // Byte exchanges needed for one word with 'remaining' burst bits left.
  function automatic int unsigned word_byte_count(input int remaining,
                                                  input int word_bits);
    int b;
    b = (remaining < word_bits) ? remaining : word_bits;
    if (b <= 0) return 0;
    return (b + 7) / 8;
  endfunction

endpackage

// File: rtl/spi_burst_counter.sv
module spi_burst_counter #(
  parameter int CNT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [CNT_W-1:0] load_val,
  input  logic                    dec,
  output logic signed [CNT_W-1:0] count,
  output logic                    spent
);
  localparam logic signed [CNT_W-1:0] STEP = CNT_W'(8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - STEP;
  end

  assign spent = (count <= 0);
endmodule

// File: rtl/spi_rx_assembler.sv
module spi_rx_assembler #(
  parameter int WORD_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             wr_en,
  input  logic [$clog2(WORD_W/8)-1:0]      wr_lane,
  input  logic [7:0]                       wr_byte,
  output logic [WORD_W-1:0]                word
);
  localparam int LANES = WORD_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             word[8*g +: 8] <= '0;
      else if (clear)                         word[8*g +: 8] <= '0;
      else if (wr_en && (int'(wr_lane) == g)) word[8*g +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len_field,
  input  logic              mode_master,
  input  logic              mode_smc,
  input  logic              mode_ss_wave,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [7:0]        byte_out,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  output logic              busy,
  output logic              xch,
  output logic              tc_set,
  output logic              ovf_set
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = LANE_W + 1;
  localparam int CNT_W  = LEN_W + 2;

  eng_state_t state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q, nbytes_q;
  logic              xch_q;

  // Named internal events
  logic multi_mode;
  logic word_fetch;
  logic byte_done;
  logic last_byte;
  logic burst_end;

  logic signed [CNT_W-1:0] cnt, load_val, eff_cnt;
  logic                    cnt_spent;
  logic [LANE_W-1:0]       lane;

  assign multi_mode = mode_master & ~mode_smc & mode_ss_wave;
  assign word_fetch = (state_q == ST_FETCH) & ~tx_empty;
  assign byte_done  = (state_q == ST_WAIT) & rsp_valid;
  assign last_byte  = (idx_q == nbytes_q - IDX_W'(1));
  assign burst_end  = (state_q == ST_STORE) & cnt_spent;

  assign load_val = CNT_W'(burst_bits(32'(burst_len_field)));
  assign eff_cnt  = cnt_spent ? load_val : cnt;
  assign lane     = idx_q[LANE_W-1:0];

  spi_burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (word_fetch & cnt_spent),
    .load_val (load_val),
    .dec      (byte_done),
    .count    (cnt),
    .spent    (cnt_spent)
  );

  spi_rx_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (word_fetch),
    .wr_en   (byte_done),
    .wr_lane (lane),
    .wr_byte (rsp_byte),
    .word    (rx_data)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: state_d = tx_empty ? ST_IDLE : ST_SEND;
      ST_SEND:  if (byte_ready) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) state_d = last_byte ? ST_STORE : ST_SEND;
      ST_STORE: state_d = ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      idx_q    <= '0;
      nbytes_q <= '0;
      xch_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (word_fetch) begin
        word_q   <= tx_data;
        idx_q    <= '0;
        nbytes_q <= IDX_W'(word_byte_count(int'(eff_cnt), WORD_W));
        if (multi_mode) xch_q <= 1'b1;
      end else if ((state_q == ST_FETCH) && tx_empty) begin
        xch_q <= 1'b0;
      end
      if (byte_done) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign tx_pop     = word_fetch;
  assign byte_valid = (state_q == ST_SEND);
  assign byte_out   = word_q[8*int'(lane) +: 8];
  assign rx_push    = (state_q == ST_STORE) & ~rx_full;
  assign ovf_set    = (state_q == ST_STORE) & rx_full;
  assign tc_set     = (burst_end & ~multi_mode) | ((state_q == ST_FETCH) & tx_empty);
  assign busy       = (state_q != ST_IDLE);
  assign xch        = xch_q;
endmodule

// File: rtl/spi_burst_engine_checks.sv
module spi_burst_engine_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       tx_empty,
  input logic       tx_pop,
  input logic       rx_full,
  input logic       rx_push,
  input logic       ovf_set,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_out,
  input logic       tc_set,
  input logic       xch,
  input logic       multi_mode
);
  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  assert_pop_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);

  assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |-> (rx_full && !rx_push));

  assert_byte_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_out)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!byte_valid && !tx_pop && !rx_push && !ovf_set));

  assert_multi_no_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_push || ovf_set) && multi_mode) |-> !tc_set);

  assert_xch_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !xch);
endmodule

bind spi_burst_engine spi_burst_engine_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .tx_empty   (tx_empty),
  .tx_pop     (tx_pop),
  .rx_full    (rx_full),
  .rx_push    (rx_push),
  .ovf_set    (ovf_set),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_out   (byte_out),
  .tc_set     (tc_set),
  .xch        (xch),
  .multi_mode (multi_mode)
);

// File: tb/spi_burst_engine_test.sv
module spi_burst_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] burst_len_field = '0;
  logic mode_master = 1'b0, mode_smc = 1'b0, mode_ss_wave = 1'b0;
  logic tx_empty;
  logic [31:0] tx_data;
  logic tx_pop;
  logic rx_full = 1'b0;
  logic rx_push;
  logic [31:0] rx_data;
  logic byte_valid;
  logic byte_ready = 1'b0;
  logic [7:0] byte_out;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_byte = '0;
  logic busy, xch, tc_set, ovf_set;

  always #5 clk = ~clk;

  spi_burst_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len_field(burst_len_field),
    .mode_master(mode_master), .mode_smc(mode_smc), .mode_ss_wave(mode_ss_wave),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_out(byte_out),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .busy(busy), .xch(xch), .tc_set(tc_set), .ovf_set(ovf_set)
  );

  int errors = 0, checks = 0;
  logic tb_clear = 1'b0;

  // Transmit queue model
  logic [31:0] words [0:15];
  int n_words = 0;
  int rd_ptr = 0;
  assign tx_empty = (rd_ptr >= n_words);
  assign tx_data  = (rd_ptr < n_words) ? words[rd_ptr] : 32'h0;
  always @(posedge clk) begin
    if (tb_clear) rd_ptr <= 0;
    else if (tx_pop) rd_ptr <= rd_ptr + 1;
  end

  // Shifter model and monitors, all on the falling edge
  logic [7:0] sent_log [0:127];
  logic [31:0] rx_log [0:15];
  int n_sent = 0, n_rx = 0, n_tc = 0, n_ovf = 0;
  bit xch_seen = 0;
  bit pend = 0;
  int dly = 0;
  logic [7:0] pend_byte = '0;

  always @(negedge clk) begin
    if (tb_clear) begin
      n_sent = 0; n_rx = 0; n_tc = 0; n_ovf = 0; xch_seen = 0;
    end else begin
      if (tc_set) n_tc++;
      if (ovf_set) n_ovf++;
      if (rx_push && n_rx < 16) begin rx_log[n_rx] = rx_data; n_rx++; end
      if (xch) xch_seen = 1;
    end
    if (byte_ready) begin
      byte_ready <= 1'b0;
      pend = 1;
      dly = $urandom % 3;
    end else if (pend) begin
      if (rsp_valid) begin
        rsp_valid <= 1'b0;
        pend = 0;
      end else if (dly == 0) begin
        rsp_valid <= 1'b1;
        rsp_byte  <= pend_byte;
      end else dly--;
    end else if (byte_valid && ($urandom % 2 == 0)) begin
      byte_ready <= 1'b1;
      if (n_sent < 128) sent_log[n_sent] = byte_out;
      n_sent++;
      pend_byte = byte_out ^ 8'h3C;
    end
  end

  // Reference model
  int model_cnt = 0;
  logic [7:0] exp_bytes [0:127];
  logic [31:0] exp_rx [0:15];
  int exp_nb, exp_tc, exp_nrx, exp_ovf;

  function automatic int bytes_for(int remaining);
    int bits;
    bits = (remaining > 32) ? 32 : remaining;
    return (bits + 7) / 8;
  endfunction

  task automatic model_run(int len, bit multi, bit full, int n);
    exp_nb = 0; exp_tc = 0; exp_nrx = 0; exp_ovf = 0;
    for (int w = 0; w < n; w++) begin
      logic [31:0] acc;
      int nb;
      if (model_cnt <= 0) model_cnt = len + 1;          // R1
      nb = bytes_for(model_cnt);                          // R2
      acc = 32'h0;
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b;
        b = words[w][8*i +: 8];                           // R3
        exp_bytes[exp_nb] = b;
        exp_nb++;
        acc[8*i +: 8] = b ^ 8'h3C;                        // R4
        model_cnt -= 8;
      end
      if (full) exp_ovf++;                                // R5
      else begin exp_rx[exp_nrx] = acc; exp_nrx++; end
      if (model_cnt <= 0 && !multi) exp_tc++;             // R7
    end
    exp_tc++;                                             // R8
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic scenario(int len, bit m, bit s, bit w, bit full, int n,
                          bit fixed_words, string tag);
    bit multi;
    bit busy_seen;
    int t;
    multi = m & ~s & w;
    @(negedge clk);
    burst_len_field = 12'(len);
    mode_master = m; mode_smc = s; mode_ss_wave = w; rx_full = full;
    n_words = n;
    if (!fixed_words) for (int k = 0; k < n; k++) words[k] = $urandom;
    tb_clear = 1'b1;
    @(negedge clk);
    tb_clear = 1'b0;
    model_run(len, multi, full, n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    check(busy_seen, {tag, " R9 busy after start"}, busy, 1);
    repeat (2) @(negedge clk);
    if (busy) begin start = 1'b1; @(negedge clk); start = 1'b0; end  // R9 ignored
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(!busy, {tag, " R9 returns idle"}, busy, 0);
    check(rd_ptr == n, {tag, " R11 one pop per word"}, rd_ptr, n);
    check(n_sent == exp_nb, {tag, " R1 R2 byte count"}, n_sent, exp_nb);
    for (int i = 0; i < exp_nb && i < n_sent; i++)
      if (sent_log[i] !== exp_bytes[i]) begin
        check(0, {tag, " R3 byte order"}, sent_log[i], exp_bytes[i]);
        break;
      end
    check(n_rx == exp_nrx, {tag, " R5 push count"}, n_rx, exp_nrx);
    check(n_ovf == exp_ovf, {tag, " R5 overflow count"}, n_ovf, exp_ovf);
    for (int i = 0; i < exp_nrx && i < n_rx; i++)
      if (rx_log[i] !== exp_rx[i]) begin
        check(0, {tag, " R4 rx word"}, rx_log[i], exp_rx[i]);
        break;
      end
    check(n_tc == exp_tc, {tag, " R7 R8 tc count"}, n_tc, exp_tc);
    check(xch == 1'b0, {tag, " R8 xch cleared"}, xch, 0);
    check(xch_seen == (multi && n > 0), {tag, " R6 xch held"}, xch_seen, multi && n > 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !byte_valid && !xch && !tc_set && !tx_pop, "R9 reset state", busy, 0);

    scenario(7, 0, 0, 0, 0, 0, 0, "empty");                 // R8
    scenario(7, 1, 1, 0, 0, 3, 0, "len8");                  // R1 one byte per word
    words[0] = 32'h44332211; words[1] = 32'hDDCCBBAA; words[2] = 32'h0F0E0D0C;
    scenario(39, 0, 0, 0, 0, 3, 1, "len40");                // R2 R3
    scenario(11, 0, 0, 0, 0, 2, 0, "len12");                // R4 zero upper lanes
    scenario(63, 1, 0, 1, 0, 4, 0, "multi");                // R6 R7
    scenario(20, 0, 0, 0, 1, 3, 0, "full");                 // R5
    for (int r = 0; r < 12; r++) begin
      int len;
      len = $urandom % 100;
      scenario(len, 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom % 4 == 0), 1 + $urandom % 5, 0, "rand");
    end
    finish_run();
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule